// File: doc/BRIEF.md
# Boot Progress Code Seven-Segment Serial Driver

This block listens to a simple host I/O write interface and picks out the byte writes aimed at the host's boot-progress port (I/O address 0x80). Each byte it picks up is shown as two hexadecimal digits. The upper nibble and the lower nibble each pass through a fixed 16-entry table that gives an active-low seven-segment pattern. The two pattern bytes are then bit-banged out on a data wire and a shift-clock wire to two external 8-bit shift registers wired in a chain. After the last bit, a one-cycle latch strobe tells the displays to update.

A write that arrives while a frame is still going out is held in a single pending slot. A later write replaces the held value, so the displays always catch up to the newest code once the frame in flight has finished. The block raises `busy` while a frame is being shifted.

Top module: `postcode_seg_driver`

## Requirements
- R1: A write is captured only when `io_wr_en` is high and the full `io_addr` equals 0x0080. Writes to any other address, and cycles with `io_wr_en` low, start no frame and leave the pending value untouched.
- R2: Nibble values 0 through F map to the active-low patterns C0, F9, A4, B0, 99, 92, 82, F8, 80, 90, 88, 83, C6, A1, 86, 8E (hex), in that order of nibble value.
- R3: Each frame is exactly 16 bits. The pattern of the upper nibble goes first, then the pattern of the lower nibble, and each byte is sent MSB first. After 16 clocks the upper digit therefore sits in the far register.
- R4: `ser_data` changes only on the cycle that `ser_clk` falls, or while `ser_clk` is low, so it is stable through every high phase. Each `ser_clk` period lasts 2*HALF_CYC system cycles.
- R5: After the falling edge of the 16th shift clock, `latch_pulse` is high for exactly one cycle, with `ser_clk` and `ser_data` both low. It goes high 1+32*HALF_CYC clock edges after the edge that captured the write.
- R6: `busy` rises on the clock edge after the capturing edge and stays high until the cycle after the latch strobe. `ser_clk` never toggles while `busy` is low.
- R7: If more than one matching write arrives while a frame is in progress, only the last one is kept. It is sent as exactly one further frame once the current frame has finished.
- R8: A synchronous active-high reset drives `ser_data`, `ser_clk`, `latch_pulse` and `busy` low, drops any pending value and aborts a frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr_en | input | 1 | Host I/O write strobe, one cycle per write |
| io_addr | input | ADDR_W (16) | Host I/O write address |
| io_wdata | input | 8 | Host I/O write data byte |
| ser_data | output | 1 | Serial segment data to the shift-register chain |
| ser_clk | output | 1 | Shift clock to the chain, idle low |
| latch_pulse | output | 1 | One-cycle strobe that updates the displays |
| busy | output | 1 | High while a frame is being shifted |

## Verification
A write sampled at edge E0 sits in the pending slot after E0. `busy` rises after E0+1, the first shift-clock rise comes HALF_CYC edges later, and `latch_pulse` is high after edge E0+1+32*HALF_CYC. The bench drives inputs just after falling clock edges and samples ports at falling edges. It counts rising clock edges from the capturing edge and compares that count against this exact figure. The serial bits are collected on each `ser_clk` rise and compared as a whole frame when the strobe is seen. The bench also checks the spacing between shift-clock rises and watches for any data change during a high phase. For the ignore and overwrite cases, the bench waits well past the point where a frame would have started or finished before it checks the frame count.

// File: rtl/pcsd_pkg.sv
package pcsd_pkg;

    localparam int DIGIT_BITS = 4;
    localparam int SEG_BITS   = 8;
    localparam int NUM_DIGITS = 2;
    localparam int FRAME_BITS = SEG_BITS * NUM_DIGITS;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_LOW   = 2'd1,
        SH_HIGH  = 2'd2,
        SH_LATCH = 2'd3
    } sh_state_e;

    // Captured code split into digits, upper digit in the top slot.
    typedef struct packed {
        logic [DIGIT_BITS-1:0] upper;
        logic [DIGIT_BITS-1:0] lower;
    } post_code_t;

    // Pattern pair in transmit order: upper digit leaves first.
    typedef struct packed {
        logic [SEG_BITS-1:0] upper_seg;
        logic [SEG_BITS-1:0] lower_seg;
    } seg_frame_t;

    // Active-low hex glyphs: bit 7 is the decimal point (always off).
    function automatic logic [SEG_BITS-1:0] hex_glyph(input logic [DIGIT_BITS-1:0] nib);
        logic [SEG_BITS-1:0] g;
        case (nib)
            4'h0: g = 8'hC0;
            4'h1: g = 8'hF9;
            4'h2: g = 8'hA4;
            4'h3: g = 8'hB0;
            4'h4: g = 8'h99;
            4'h5: g = 8'h92;
            4'h6: g = 8'h82;
            4'h7: g = 8'hF8;
            4'h8: g = 8'h80;
            4'h9: g = 8'h90;
            4'hA: g = 8'h88;
            4'hB: g = 8'h83;
            4'hC: g = 8'hC6;
            4'hD: g = 8'hA1;
            4'hE: g = 8'h86;
            default: g = 8'h8E;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/pcsd_capture.sv
module pcsd_capture
    import pcsd_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] PORT_ADDR = 16'h0080
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              take,
    output logic              pend_valid,
    output post_code_t        pend_code
);

    localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(PORT_ADDR);

    logic hit;
    assign hit = wr_en && (addr == MATCH);

    // One-deep slot: a new hit always overwrites, and wins over a take.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid <= 1'b0;
            pend_code  <= '0;
        end else if (hit) begin
            pend_valid <= 1'b1;
            pend_code  <= post_code_t'(wdata);
        end else if (take) begin
            pend_valid <= 1'b0;
        end
    end

    assert_ignore_miss_R1: assert property (@(posedge clk) disable iff (rst)
        (!hit && !take) |=> (pend_valid == $past(pend_valid)) && (pend_code == $past(pend_code)));

    assert_newest_kept_R7: assert property (@(posedge clk) disable iff (rst)
        hit |=> pend_valid && (pend_code == post_code_t'($past(wdata))));

endmodule

// File: rtl/pcsd_encoder.sv
module pcsd_encoder
    import pcsd_pkg::*;
(
    input  post_code_t code,
    output seg_frame_t frame
);

    logic [DIGIT_BITS-1:0] nib   [NUM_DIGITS];
    logic [SEG_BITS-1:0]   glyph [NUM_DIGITS];

    assign nib[0] = code.upper;
    assign nib[1] = code.lower;

    for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
        assign glyph[d] = hex_glyph(nib[d]);
    end

    assign frame.upper_seg = glyph[0];
    assign frame.lower_seg = glyph[1];

endmodule

// File: rtl/pcsd_serializer.sv
module pcsd_serializer
    import pcsd_pkg::*;
#(
    parameter int HALF_CYC = 2,
    parameter int NBITS    = FRAME_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NBITS-1:0] frame_in,
    output logic             take,
    output logic             ser_data,
    output logic             ser_clk,
    output logic             latch_pulse,
    output logic             busy
);

    localparam int CNT_W = $clog2(HALF_CYC) + 1;
    localparam int IDX_W = $clog2(NBITS);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_CYC - 1);
    localparam logic [IDX_W-1:0] BIT_LAST  = IDX_W'(NBITS - 1);

    sh_state_e        state;
    logic [CNT_W-1:0] half_cnt;
    logic [IDX_W-1:0] bit_idx;
    logic [NBITS-1:0] shreg;
    logic             half_done;

    assign half_done = (half_cnt == HALF_LAST);
    assign take      = (state == SH_IDLE) && start;
    assign busy      = (state != SH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SH_IDLE;
            half_cnt    <= '0;
            bit_idx     <= '0;
            shreg       <= '0;
            ser_data    <= 1'b0;
            ser_clk     <= 1'b0;
            latch_pulse <= 1'b0;
        end else begin
            latch_pulse <= 1'b0;
            case (state)
                SH_IDLE: begin
                    if (start) begin
                        shreg    <= frame_in;
                        ser_data <= frame_in[NBITS-1];
                        ser_clk  <= 1'b0;
                        half_cnt <= '0;
                        bit_idx  <= '0;
                        state    <= SH_LOW;
                    end
                end
                SH_LOW: begin
                    if (half_done) begin
                        half_cnt <= '0;
                        ser_clk  <= 1'b1;
                        state    <= SH_HIGH;
                    end else begin
                        half_cnt <= half_cnt + 1'b1;
                    end
                end
                SH_HIGH: begin
                    if (half_done) begin
                        half_cnt <= '0;
                        ser_clk  <= 1'b0;
                        if (bit_idx == BIT_LAST) begin
                            ser_data    <= 1'b0;
                            latch_pulse <= 1'b1;
                            state       <= SH_LATCH;
                        end else begin
                            bit_idx  <= bit_idx + 1'b1;
                            shreg    <= {shreg[NBITS-2:0], 1'b0};
                            ser_data <= shreg[NBITS-2];
                            state    <= SH_LOW;
                        end
                    end else begin
                        half_cnt <= half_cnt + 1'b1;
                    end
                end
                default: begin
                    state <= SH_IDLE;
                end
            endcase
        end
    end

    assert_data_steady_high_R4: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> $stable(ser_data));

    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
        latch_pulse |=> !latch_pulse);

    assert_strobe_lines_low_R5: assert property (@(posedge clk) disable iff (rst)
        latch_pulse |-> (!ser_clk && !ser_data));

    assert_clk_only_busy_R6: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> busy);

endmodule

// File: rtl/postcode_seg_driver.sv
module postcode_seg_driver
    import pcsd_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] PORT_ADDR = 16'h0080,
    parameter int          HALF_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr_en,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              latch_pulse,
    output logic              busy
);

    logic       pend_valid;
    logic       take;
    post_code_t pend_code;
    seg_frame_t frame;

    pcsd_capture #(
        .ADDR_W    (ADDR_W),
        .PORT_ADDR (PORT_ADDR)
    ) capture_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (io_wr_en),
        .addr       (io_addr),
        .wdata      (io_wdata),
        .take       (take),
        .pend_valid (pend_valid),
        .pend_code  (pend_code)
    );

    pcsd_encoder encoder_i (
        .code  (pend_code),
        .frame (frame)
    );

    pcsd_serializer #(
        .HALF_CYC (HALF_CYC),
        .NBITS    (FRAME_BITS)
    ) serializer_i (
        .clk         (clk),
        .rst         (rst),
        .start       (pend_valid),
        .frame_in    (frame),
        .take        (take),
        .ser_data    (ser_data),
        .ser_clk     (ser_clk),
        .latch_pulse (latch_pulse),
        .busy        (busy)
    );

    assert_reset_idle_R8: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !ser_clk && !ser_data && !latch_pulse));

endmodule

// File: tb/postcode_seg_driver_tb_top.sv
module postcode_seg_driver_tb_top;

    localparam int HALF    = 2;
    localparam int LAT_DLY = 1 + 32 * HALF;
    localparam int NVEC    = 9;

    // {code, expected frame}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h00, 16'hC0C0}, {8'h5A, 16'h9288}, {8'hFF, 16'h8E8E},
        {8'h3C, 16'hB0C6}, {8'h81, 16'h80F9}, {8'hD7, 16'hA1F8},
        {8'h26, 16'hA482}, {8'hE9, 16'h8690}, {8'hB4, 16'h8399}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_wr_en = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        ser_data, ser_clk, latch_pulse, busy;

    int checks = 0;
    int errors = 0;

    postcode_seg_driver #(.ADDR_W(16), .PORT_ADDR(16'h0080), .HALF_CYC(HALF)) dut_i (
        .clk (clk), .rst (rst), .io_wr_en (io_wr_en), .io_addr (io_addr),
        .io_wdata (io_wdata), .ser_data (ser_data), .ser_clk (ser_clk),
        .latch_pulse (latch_pulse), .busy (busy)
    );

    always #4 clk = ~clk;

    // Monitor: collect bits on shift-clock rises, store frames on strobe.
    int          cyc = 0;
    int          last_rise = 0;
    int          period_bad = 0;
    int          glitch = 0;
    int          bit_cnt = 0;
    logic [15:0] acc = '0;
    int          nfr = 0;
    logic [15:0] frames [64];
    int          fbits [64];

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge ser_clk) begin
        if (bit_cnt > 0 && (cyc - last_rise) != 2 * HALF) period_bad++;
        last_rise = cyc;
        acc = {acc[14:0], ser_data};
        bit_cnt++;
    end

    always @(ser_data) if (ser_clk && !rst) glitch++;

    always @(negedge clk) begin
        if (latch_pulse && nfr < 64) begin
            frames[nfr] = acc;
            fbits[nfr]  = bit_cnt;
            nfr++;
            bit_cnt = 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input logic en);
        @(negedge clk);
        io_wr_en = en; io_addr = a; io_wdata = d;
        @(posedge clk);
        @(negedge clk);
        io_wr_en = 1'b0; io_addr = '0; io_wdata = '0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_frames(input int target);
        for (int i = 0; i < 2000 && nfr < target; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        idle_cycles(3);
        rst = 1'b0; bit_cnt = 0;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual 0x%0h expected 0x%0h", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n0;
        int cnt;
        idle_cycles(3);
        // R8: outputs during and right after reset
        check(!ser_data && !ser_clk && !busy && !latch_pulse, "R8 reset outputs",
              {ser_data, ser_clk, busy, latch_pulse}, 0);
        rst = 1'b0;
        idle_cycles(2);

        // Vector walk: R2/R3 frame contents, R5 strobe delay, R6 busy edges
        for (int v = 0; v < NVEC; v++) begin
            n0 = nfr;
            @(negedge clk);
            io_wr_en = 1'b1; io_addr = 16'h0080; io_wdata = VEC[v][23:16];
            @(posedge clk);            // capturing edge E0
            @(negedge clk);
            io_wr_en = 1'b0; io_addr = '0;
            check(!busy, "R6 busy low after capture edge", busy, 0);
            cnt = 0;
            for (int i = 0; i < 500; i++) begin
                @(posedge clk); cnt++;
                @(negedge clk);
                if (cnt == 1) check(busy, "R6 busy high after next edge", busy, 1);
                if (latch_pulse) break;
            end
            check(cnt == LAT_DLY, "R5 strobe delay", cnt, LAT_DLY);
            check(!ser_clk && !ser_data, "R5 lines low at strobe", {ser_clk, ser_data}, 0);
            @(negedge clk);
            check(!latch_pulse && !busy, "R5 R6 strobe one cycle then idle",
                  {latch_pulse, busy}, 0);
            check(nfr == n0 + 1 && frames[n0] == VEC[v][15:0], "R2 R3 frame pattern",
                  frames[n0], VEC[v][15:0]);
            check(fbits[n0] == 16, "R3 bit count", fbits[n0], 16);
        end

        // R1: non-matching writes are ignored
        n0 = nfr;
        bus_write(16'h0081, 8'h11, 1'b1);
        bus_write(16'h0180, 8'h22, 1'b1);
        bus_write(16'h0000, 8'h80, 1'b1);
        bus_write(16'h0080, 8'h33, 1'b0);
        idle_cycles(10);
        check(!busy, "R1 no frame started", busy, 0);
        idle_cycles(100);
        check(nfr == n0, "R1 frame count unchanged", nfr - n0, 0);

        // R7: overwrite during a frame, newest value sent once
        n0 = nfr;
        bus_write(16'h0080, 8'h12, 1'b1);
        idle_cycles(10);
        bus_write(16'h0080, 8'h34, 1'b1);
        bus_write(16'h0080, 8'h56, 1'b1);
        wait_frames(n0 + 2);
        idle_cycles(200);
        check(nfr == n0 + 2, "R7 exactly two frames", nfr - n0, 2);
        check(frames[n0] == 16'hF9A4, "R7 first frame", frames[n0], 16'hF9A4);
        check(frames[n0 + 1] == 16'h9282, "R7 newest frame", frames[n0 + 1], 16'h9282);

        // R4: timing of data against the shift clock over all frames so far
        check(period_bad == 0, "R4 shift clock period", period_bad, 0);
        check(glitch == 0, "R4 data stable while clock high", glitch, 0);

        // R8: reset aborts a frame in progress and drops the pending value
        n0 = nfr;
        bus_write(16'h0080, 8'h77, 1'b1);
        idle_cycles(20);
        bus_write(16'h0080, 8'h99, 1'b1);
        do_reset();
        check(!ser_data && !ser_clk && !busy && !latch_pulse, "R8 abort outputs",
              {ser_data, ser_clk, busy, latch_pulse}, 0);
        idle_cycles(200);
        check(nfr == n0 && !busy, "R8 no frame after reset", nfr - n0, 0);

        // Back-to-back after reset still works
        n0 = nfr;
        bus_write(16'h0080, 8'hA0, 1'b1);
        wait_frames(n0 + 1);
        check(nfr == n0 + 1 && frames[n0] == 16'h88C0, "R3 frame after reset",
              frames[n0], 16'h88C0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule